// File: doc/BRIEF.md
# Exception entry controller

This block is the part of a small 32-bit processor's control unit that records what happens when the core takes an exception. It accepts a general exception request and a debug exception request. A general request carries a cause code, the faulting PC and, when it has one, a faulting virtual address. A debug request carries its own cause and PC. In one clock edge the block updates the processor status word and the save registers the request calls for. One cycle later it presents a 3-bit vector code that tells the fetch logic where to go.

The status word has three fields. The current interrupt level sits in bits 3:0, the in-exception flag in bit 4 and the user-mode flag in bit 5. A general request that arrives while the in-exception flag is already set is a nested fault. It is sent to the nested-fault vector, and its PC goes to a dedicated nested-fault PC register when that register is configured. A debug request is accepted only while the interrupt level is below the configured debug level. When accepted, it saves the old status into that level's slot of the level bank and raises the interrupt level to the debug level. The rest of the core can load the status word through a write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After a synchronous reset every register output reads zero and `vec_o` reads 0 (none).
- R2: A general request taken while status bit 4 is 0 loads `exc_pc_i` into `ret_pc1_o`. The next cycle `vec_o` reads 1 (user) if status bit 5 is 1, and 2 (kernel) if it is 0.
- R3: A general request taken while status bit 4 is 1 gives `vec_o` = 3 (nested fault). With `HAS_DBL_PC`=1 the PC goes to `dbl_ret_pc_o` and `ret_pc1_o` is unchanged. With `HAS_DBL_PC`=0 the PC goes to `ret_pc1_o` and `dbl_ret_pc_o` stays 0.
- R4: Every taken general request writes its cause into `cause_o` and sets status bit 4. Status bits 5 and 3:0 are kept.
- R5: `fault_addr_o` is loaded from `exc_vaddr_i` only on a taken general request with `exc_addr_vld_i` = 1. Otherwise it holds its value.
- R6: A debug request with status bits 3:0 below `DBG_LEVEL` is taken. It loads `dbg_cause_i` into `dbg_cause_o`. It writes `dbg_pc_i` and the old status word into the level-bank slot for `DBG_LEVEL` (slot index `DBG_LEVEL`-2, 32 PC bits and 6 status bits per slot). Status becomes bit 5 kept, bit 4 = 1, bits 3:0 = `DBG_LEVEL`. The next cycle `vec_o` = 4 (debug).
- R7: A debug request with status bits 3:0 at or above `DBG_LEVEL` changes no register. If no general request arrives in the same cycle, `vec_o` reads 0 the next cycle.
- R8: When both requests arrive in one cycle, a taken debug request wins and the general request changes nothing. If the debug request is masked, the general request is taken as usual.
- R9: `vec_o` is 0 in every cycle that does not follow a taken request.
- R10: `stat_wr_i` loads `stat_wdata_i` into the status word only in a cycle with no request. It is ignored while either request input is high.
- R11: Level-bank slots other than the `DBG_LEVEL` slot always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req_i | input | 1 | General exception request |
| exc_cause_i | input | CAUSE_W | General exception cause code |
| exc_pc_i | input | XLEN | PC of the faulting instruction |
| exc_addr_vld_i | input | 1 | The request carries a faulting address |
| exc_vaddr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| dbg_pc_i | input | XLEN | PC for the debug exception |
| stat_wr_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | 6 | Status word write data |
| stat_o | output | 6 | Status word (bit 5 user, bit 4 in-exception, bits 3:0 level) |
| ret_pc1_o | output | XLEN | First-level return PC |
| dbl_ret_pc_o | output | XLEN | Nested-fault return PC |
| cause_o | output | CAUSE_W | Recorded general cause |
| fault_addr_o | output | XLEN | Recorded faulting address |
| dbg_cause_o | output | DCAUSE_W | Recorded debug cause |
| lvl_pc_o | output | 5*XLEN | Level-bank PCs, levels 2..6, level 2 in the low slot |
| lvl_stat_o | output | 5*6 | Level-bank saved status words, same slot order |
| vec_o | output | 3 | Vector code: 0 none, 1 user, 2 kernel, 3 nested, 4 debug |

## Verification
The hardest situations to reach are those that depend on the status word before the request. Examples are a nested fault in user mode, a debug request exactly at the masking level, and a masked debug request that arrives together with a general request. The stimulus reaches each one by loading a chosen status word through the write port and then issuing the request. A table drives this over every combination of in-exception and user-mode flags. Two instances, one with the nested-fault PC register and one without, are compared against a model in the bench. Directed steps then chain two faults with no status write between them. They also collide a status write with a request.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STAT_W   = 6;
  localparam int ILVL_W   = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;
  localparam int MIN_LVL  = 2;
  localparam int MAX_LVL  = 6;
  localparam int NLVL     = MAX_LVL - MIN_LVL + 1;

  typedef enum logic [2:0] {
    VEC_NONE   = 3'd0,
    VEC_USER   = 3'd1,
    VEC_KERNEL = 3'd2,
    VEC_DOUBLE = 3'd3,
    VEC_DEBUG  = 3'd4
  } vec_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int DBG_LEVEL = 3
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic              exc_req_i,
  input  logic              dbg_req_i,
  output logic              take_gen_o,
  output logic              take_dbg_o,
  output vec_e              vec_o
);
  logic dbg_open;

  // debug accepted only below its own level
  assign dbg_open   = stat_i[ILVL_W-1:0] < ILVL_W'(DBG_LEVEL);
  assign take_dbg_o = dbg_req_i && dbg_open;
  assign take_gen_o = exc_req_i && !take_dbg_o;

  always_comb begin
    vec_o = VEC_NONE;
    if (take_dbg_o)                vec_o = VEC_DEBUG;
    else if (take_gen_o) begin
      if (stat_i[EXCM_BIT])        vec_o = VEC_DOUBLE;
      else if (stat_i[UM_BIT])     vec_o = VEC_USER;
      else                         vec_o = VEC_KERNEL;
    end
  end
endmodule

// File: rtl/exc_gen_regs.sv
module exc_gen_regs #(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter bit HAS_DBL_PC = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic               in_exc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               addr_vld_i,
  input  logic [XLEN-1:0]    vaddr_i,
  output logic [XLEN-1:0]    ret_pc1_o,
  output logic [XLEN-1:0]    dbl_pc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    vaddr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o <= '0;
      vaddr_o <= '0;
    end else if (take_i) begin
      cause_o <= cause_i;
      if (addr_vld_i) vaddr_o <= vaddr_i;
    end
  end

  generate
    if (HAS_DBL_PC) begin : g_dbl
      always_ff @(posedge clk) begin
        if (rst) begin
          ret_pc1_o <= '0;
          dbl_pc_o  <= '0;
        end else if (take_i) begin
          if (in_exc_i) dbl_pc_o  <= pc_i;
          else          ret_pc1_o <= pc_i;
        end
      end

      // R3: nested fault leaves the first-level PC alone
      a_r3_pc1_kept : assert property (@(posedge clk) disable iff (rst)
        (take_i && in_exc_i) |=> $stable(ret_pc1_o));
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)         ret_pc1_o <= '0;
        else if (take_i) ret_pc1_o <= pc_i;
      end
      assign dbl_pc_o = '0;
    end
  endgenerate

  // R5: address only captured when flagged
  a_r5_addr_hold : assert property (@(posedge clk) disable iff (rst)
    !(take_i && addr_vld_i) |=> $stable(vaddr_o));
endmodule

// File: rtl/exc_dbg_regs.sv
module exc_dbg_regs
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int DCAUSE_W  = 6,
  parameter int DBG_LEVEL = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take_i,
  input  logic [DCAUSE_W-1:0]    cause_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic [STAT_W-1:0]      stat_old_i,
  output logic [DCAUSE_W-1:0]    cause_o,
  output logic [NLVL*XLEN-1:0]   lvl_pc_o,
  output logic [NLVL*STAT_W-1:0] lvl_stat_o
);
  localparam int SLOT = DBG_LEVEL - MIN_LVL;

  always_ff @(posedge clk) begin
    if (rst)         cause_o <= '0;
    else if (take_i) cause_o <= cause_i;
  end

  generate
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      if (g == SLOT) begin : g_live
        always_ff @(posedge clk) begin
          if (rst) begin
            lvl_pc_o[g*XLEN +: XLEN]       <= '0;
            lvl_stat_o[g*STAT_W +: STAT_W] <= '0;
          end else if (take_i) begin
            lvl_pc_o[g*XLEN +: XLEN]       <= pc_i;
            lvl_stat_o[g*STAT_W +: STAT_W] <= stat_old_i;
          end
        end
      end else begin : g_idle
        assign lvl_pc_o[g*XLEN +: XLEN]       = '0;
        assign lvl_stat_o[g*STAT_W +: STAT_W] = '0;
      end
    end
  endgenerate

  // R6: saved status is the word before entry
  a_r6_saved_stat : assert property (@(posedge clk) disable iff (rst)
    take_i |=> (lvl_stat_o[SLOT*STAT_W +: STAT_W] == $past(stat_old_i)));
  // R11: bank only moves on a taken debug request
  a_r11_bank_quiet : assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(lvl_pc_o) && $stable(lvl_stat_o)));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int DCAUSE_W   = 6,
  parameter int DBG_LEVEL  = 3,
  parameter bit HAS_DBL_PC = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   exc_req_i,
  input  logic [CAUSE_W-1:0]     exc_cause_i,
  input  logic [XLEN-1:0]        exc_pc_i,
  input  logic                   exc_addr_vld_i,
  input  logic [XLEN-1:0]        exc_vaddr_i,
  input  logic                   dbg_req_i,
  input  logic [DCAUSE_W-1:0]    dbg_cause_i,
  input  logic [XLEN-1:0]        dbg_pc_i,
  input  logic                   stat_wr_i,
  input  logic [5:0]             stat_wdata_i,
  output logic [5:0]             stat_o,
  output logic [XLEN-1:0]        ret_pc1_o,
  output logic [XLEN-1:0]        dbl_ret_pc_o,
  output logic [CAUSE_W-1:0]     cause_o,
  output logic [XLEN-1:0]        fault_addr_o,
  output logic [DCAUSE_W-1:0]    dbg_cause_o,
  output logic [5*XLEN-1:0]      lvl_pc_o,
  output logic [5*6-1:0]         lvl_stat_o,
  output logic [2:0]             vec_o
);
  logic [STAT_W-1:0] stat_q;
  logic              take_gen, take_dbg;
  vec_e              vec_nxt, vec_q;

  exc_arbiter #(.DBG_LEVEL(DBG_LEVEL)) u_arb (
    .stat_i     (stat_q),
    .exc_req_i  (exc_req_i),
    .dbg_req_i  (dbg_req_i),
    .take_gen_o (take_gen),
    .take_dbg_o (take_dbg),
    .vec_o      (vec_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      vec_q  <= VEC_NONE;
    end else begin
      vec_q <= vec_nxt;
      if (take_dbg) begin
        stat_q[ILVL_W-1:0] <= ILVL_W'(DBG_LEVEL);
        stat_q[EXCM_BIT]   <= 1'b1;
      end else if (take_gen) begin
        stat_q[EXCM_BIT]   <= 1'b1;
      end else if (stat_wr_i && !exc_req_i && !dbg_req_i) begin
        stat_q <= stat_wdata_i;
      end
    end
  end

  exc_gen_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_DBL_PC(HAS_DBL_PC)) u_gen (
    .clk        (clk),
    .rst        (rst),
    .take_i     (take_gen),
    .in_exc_i   (stat_q[EXCM_BIT]),
    .cause_i    (exc_cause_i),
    .pc_i       (exc_pc_i),
    .addr_vld_i (exc_addr_vld_i),
    .vaddr_i    (exc_vaddr_i),
    .ret_pc1_o  (ret_pc1_o),
    .dbl_pc_o   (dbl_ret_pc_o),
    .cause_o    (cause_o),
    .vaddr_o    (fault_addr_o)
  );

  exc_dbg_regs #(.XLEN(XLEN), .DCAUSE_W(DCAUSE_W), .DBG_LEVEL(DBG_LEVEL)) u_dbg (
    .clk        (clk),
    .rst        (rst),
    .take_i     (take_dbg),
    .cause_i    (dbg_cause_i),
    .pc_i       (dbg_pc_i),
    .stat_old_i (stat_q),
    .cause_o    (dbg_cause_o),
    .lvl_pc_o   (lvl_pc_o),
    .lvl_stat_o (lvl_stat_o)
  );

  assign stat_o = stat_q;
  assign vec_o  = vec_q;

  // R4: any request leaves the in-exception flag set
  a_r4_excm_set : assert property (@(posedge clk) disable iff (rst)
    exc_req_i |=> stat_o[EXCM_BIT]);
  // R6: accepted debug raises the level and selects the debug vector
  a_r6_level_up : assert property (@(posedge clk) disable iff (rst)
    (dbg_req_i && stat_o[3:0] < 4'(DBG_LEVEL)) |=>
      (stat_o[3:0] == 4'(DBG_LEVEL) && vec_o == VEC_DEBUG));
  // R7: masked debug alone leaves no trace
  a_r7_masked : assert property (@(posedge clk) disable iff (rst)
    (dbg_req_i && !exc_req_i && stat_o[3:0] >= 4'(DBG_LEVEL)) |=>
      (vec_o == VEC_NONE && $stable(dbg_cause_o) && $stable(stat_o)));
  // R8: debug wins over a simultaneous general request
  a_r8_dbg_wins : assert property (@(posedge clk) disable iff (rst)
    (dbg_req_i && exc_req_i && stat_o[3:0] < 4'(DBG_LEVEL)) |=>
      ($stable(cause_o) && $stable(ret_pc1_o)));
  // R9: no request, no vector
  a_r9_idle : assert property (@(posedge clk) disable iff (rst)
    (!exc_req_i && !dbg_req_i) |=> vec_o == VEC_NONE);
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  localparam int DL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        exc_req = 0, addr_vld = 0, dbg_req = 0, st_wr = 0;
  logic [5:0]  exc_cause = 0, dbg_cause = 0, st_wd = 0;
  logic [31:0] exc_pc = 0, exc_va = 0, dbg_pc = 0;

  logic [5:0]   st_o [2];
  logic [31:0]  pc1_o [2], dpc_o [2], va_o [2];
  logic [5:0]   ca_o [2], dc_o [2];
  logic [159:0] lpc_o [2];
  logic [29:0]  lst_o [2];
  logic [2:0]   vc_o [2];

  for (genvar k = 0; k < 2; k++) begin : g_dut
    exc_entry_ctrl #(.DBG_LEVEL(DL), .HAS_DBL_PC(k == 0)) u_exc_entry_ctrl (
      .clk(clk), .rst(rst), .exc_req_i(exc_req), .exc_cause_i(exc_cause),
      .exc_pc_i(exc_pc), .exc_addr_vld_i(addr_vld), .exc_vaddr_i(exc_va),
      .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause), .dbg_pc_i(dbg_pc),
      .stat_wr_i(st_wr), .stat_wdata_i(st_wd), .stat_o(st_o[k]),
      .ret_pc1_o(pc1_o[k]), .dbl_ret_pc_o(dpc_o[k]), .cause_o(ca_o[k]),
      .fault_addr_o(va_o[k]), .dbg_cause_o(dc_o[k]), .lvl_pc_o(lpc_o[k]),
      .lvl_stat_o(lst_o[k]), .vec_o(vc_o[k]));
  end

  int n_chk = 0, n_fail = 0;

  // model state
  logic [5:0]  m_st = 0, m_cause = 0, m_dc = 0;
  logic [31:0] m_pc1 [2] = '{0, 0};
  logic [31:0] m_dpc [2] = '{0, 0};
  logic [31:0] m_va = 0;
  logic [31:0] m_lpc [5] = '{0, 0, 0, 0, 0};
  logic [5:0]  m_lst [5] = '{0, 0, 0, 0, 0};
  logic [2:0]  m_vec = 0;

  // {status preload, gen, dbg, addr, cause}
  localparam logic [14:0] TBL [12] = '{
    {6'h00, 1'b1, 1'b0, 1'b1, 6'd5},
    {6'h20, 1'b1, 1'b0, 1'b0, 6'd9},
    {6'h10, 1'b1, 1'b0, 1'b1, 6'd12},
    {6'h30, 1'b1, 1'b0, 1'b0, 6'd13},
    {6'h02, 1'b0, 1'b1, 1'b0, 6'd1},
    {6'h23, 1'b0, 1'b1, 1'b0, 6'd2},
    {6'h05, 1'b0, 1'b1, 1'b0, 6'd3},
    {6'h21, 1'b1, 1'b1, 1'b1, 6'd20},
    {6'h04, 1'b1, 1'b1, 1'b1, 6'd21},
    {6'h20, 1'b1, 1'b0, 1'b1, 6'd30},
    {6'h00, 1'b0, 1'b1, 1'b0, 6'd4},
    {6'h14, 1'b1, 1'b0, 1'b1, 6'd40}
  };

  task automatic cmp(input string tag, input string nm, input int k,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s dut%0d act=%h exp=%h", tag, nm, k, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 2; k++) begin
      cmp(tag, "stat", k, 32'(st_o[k]), 32'(m_st));
      cmp(tag, "pc1", k, pc1_o[k], m_pc1[k]);
      cmp(tag, "dblpc", k, dpc_o[k], m_dpc[k]);
      cmp(tag, "cause", k, 32'(ca_o[k]), 32'(m_cause));
      cmp(tag, "vaddr", k, va_o[k], m_va);
      cmp(tag, "dcause", k, 32'(dc_o[k]), 32'(m_dc));
      cmp(tag, "vec", k, 32'(vc_o[k]), 32'(m_vec));
      for (int i = 0; i < 5; i++) begin
        cmp(tag, "lvlpc", k, lpc_o[k][i*32 +: 32], m_lpc[i]);
        cmp(tag, "lvlst", k, 32'(lst_o[k][i*6 +: 6]), 32'(m_lst[i]));
      end
    end
  endtask

  task automatic drive(input string tag, input logic g, input logic d,
                       input logic a, input logic [5:0] c,
                       input logic [31:0] pc, input logic [31:0] va,
                       input logic w, input logic [5:0] wd);
    logic tk_d, tk_g;
    tk_d = d && (m_st[3:0] < 4'(DL));
    tk_g = g && !tk_d;
    if (tk_d) begin
      m_dc = c ^ 6'h3F;
      m_lpc[DL-2] = pc ^ 32'hFFFF_0000;
      m_lst[DL-2] = m_st;
      m_st = {m_st[5], 1'b1, 4'(DL)};
      m_vec = 3'd4;
    end else if (tk_g) begin
      m_vec = m_st[4] ? 3'd3 : (m_st[5] ? 3'd1 : 3'd2);
      if (m_st[4]) m_dpc[0] = pc; else m_pc1[0] = pc;
      m_pc1[1] = pc;
      m_cause = c;
      if (a) m_va = va;
      m_st[4] = 1'b1;
    end else begin
      m_vec = 3'd0;
      if (w && !g && !d) m_st = wd;
    end
    @(negedge clk);
    exc_req = g; dbg_req = d; addr_vld = a; exc_cause = c; dbg_cause = c ^ 6'h3F;
    exc_pc = pc; dbg_pc = pc ^ 32'hFFFF_0000; exc_va = va; st_wr = w; st_wd = wd;
    @(posedge clk);
    #2;
    exc_req = 0; dbg_req = 0; addr_vld = 0; st_wr = 0;
    #6;
    check_all(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog all act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_all("R1");

    for (int i = 0; i < 12; i++) begin
      logic [14:0] e;
      string tag;
      e = TBL[i];
      drive("R10", 0, 0, 0, 6'd0, 32'd0, 32'd0, 1'b1, e[14:9]);
      if (e[7] && e[12:9] < 4'(DL)) tag = e[8] ? "R8" : "R6";
      else if (e[7])                tag = e[8] ? "R8" : "R7";
      else                          tag = e[13] ? "R3" : "R2";
      drive(tag, e[8], e[7], e[6], e[5:0], 32'h4000_0000 + 32'(i * 16),
            32'hA000_0000 + 32'(i * 256), 1'b0, 6'd0);
    end

    // back-to-back faults from a clean kernel status
    drive("R10", 0, 0, 0, 6'd0, 0, 0, 1'b1, 6'h00);
    drive("R2", 1, 0, 1, 6'd50, 32'h8000_0100, 32'hB000_0000, 1'b0, 6'd0);
    drive("R3", 1, 0, 0, 6'd51, 32'h8000_0200, 32'hB000_1000, 1'b0, 6'd0);
    drive("R9", 0, 0, 0, 6'd0, 0, 0, 1'b0, 6'd0);
    // address not flagged: held
    drive("R5", 1, 0, 0, 6'd52, 32'h8000_0300, 32'hCCCC_0000, 1'b0, 6'd0);
    // write colliding with a request is dropped
    drive("R10", 0, 0, 0, 6'd0, 0, 0, 1'b1, 6'h21);
    drive("R4", 1, 0, 1, 6'd53, 32'h8000_0400, 32'hDDDD_0000, 1'b1, 6'h3F);
    drive("R9", 0, 0, 0, 6'd0, 0, 0, 1'b0, 6'd0);
    drive("R11", 0, 0, 0, 6'd0, 0, 0, 1'b0, 6'd0);
    finish_run();
  end
endmodule